// File: doc/BRIEF.md
# Hash Rotate-XOR Mixing Unit

This block evaluates one of six fixed 32-bit mixing functions from two hash families on a single source operand. Four of them are the SHA-256 message-schedule and round functions: the two small sigmas and the two big sums. They serve SHA-224 as well, with no separate mode. The other two are the SM3 permutations P0 and P1. A 3-bit select picks the function. Every function is a fixed network of rotations, shifts and XORs, so the result always takes the same time whatever the data.

The source is XLEN bits wide, with XLEN either 32 or 64. Only the low 32 bits enter the computation. On a 64-bit build the 32-bit result is sign-extended to the full width. The result is registered once. A valid flag follows the input strobe by exactly one clock, and the result register holds its value while no request is presented. The block sits beside an integer execution pipeline and takes one request per cycle.

Top module: `hash_mix_unit`

## Requirements
- R1: With funcSel = 0 the result is rotr(x,7) ^ rotr(x,18) ^ (x >> 3), where x is srcIn[31:0].
- R2: With funcSel = 1 the result is rotr(x,17) ^ rotr(x,19) ^ (x >> 10).
- R3: With funcSel = 2 the result is rotr(x,2) ^ rotr(x,13) ^ rotr(x,22).
- R4: With funcSel = 3 the result is rotr(x,6) ^ rotr(x,11) ^ rotr(x,25).
- R5: With funcSel = 4 the result is x ^ rotl(x,9) ^ rotl(x,17).
- R6: With funcSel = 5 the result is x ^ rotl(x,15) ^ rotl(x,23).
- R7: With funcSel = 6 or 7 the result is all zeros.
- R8: When XLEN is 64, srcIn[63:32] has no effect on the result, and resultOut[63:32] equals 32 copies of resultOut[31].
- R9: Each request with inValid high is answered exactly one clock later: outValid is high in that cycle and resultOut carries the answer. The delay is the same for every data value and every select.
- R10: While rstN is low, outValid and resultOut are zero.
- R11: In a cycle after one in which inValid was low, outValid is low and resultOut keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe for this cycle |
| funcSel | input | 3 | Function select: 0..5 pick a function, 6 and 7 give zero |
| srcIn | input | XLEN | Source operand; only bits 31:0 are used |
| outValid | output | 1 | High one clock after an accepted request |
| resultOut | output | XLEN | Registered, sign-extended result |

## Verification
The bench builds two copies of the block side by side, one with XLEN = 64 and one with XLEN = 32, and drives both with the same stimulus. The 64-bit copy makes the sign extension and the ignored upper source half observable. Every operand carries a nonzero upper half, and the operand set includes values with bit 31 set and clear. The 32-bit copy confirms that the narrow build returns the same low word with no widening logic. Zero, all-ones, a walking single bit and mixed patterns are run through all eight select codes, with idle cycles interleaved to exercise holding.

// File: rtl/hash_mix_pkg.sv
package hash_mix_pkg;

  localparam int WORD   = 32;
  localparam int NUM_FN = 6;
  localparam int SEL_W  = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic              load;
    logic [NUM_FN-1:0] fnHot;
  } hashStrobeT;

  function automatic logic [WORD-1:0] rotR(input logic [WORD-1:0] v, input int unsigned n);
    return (v >> n) | (v << (WORD - n));
  endfunction

  function automatic logic [WORD-1:0] rotL(input logic [WORD-1:0] v, input int unsigned n);
    return rotR(v, WORD - n);
  endfunction

endpackage

// File: rtl/hash_mix_ctrl.sv
module hash_mix_ctrl
  import hash_mix_pkg::*;
(
  input  logic             inValid,
  input  logic [SEL_W-1:0] funcSel,
  output hashStrobeT       strobe
);

  logic [NUM_FN-1:0] hot;

  // one decode line per implemented function; codes beyond NUM_FN-1 light none
  for (genvar i = 0; i < NUM_FN; i++) begin : g_dec
    assign hot[i] = (funcSel == SEL_W'(i));
  end

  assign strobe.load  = inValid;
  assign strobe.fnHot = hot;

endmodule

// File: rtl/hash_mix_dp.sv
module hash_mix_dp
  import hash_mix_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  hashStrobeT      strobe,
  input  logic [WORD-1:0] word,
  output logic            outValid,
  output logic [XLEN-1:0] resultOut
);

  localparam int EXT_W = XLEN - WORD;

  logic [WORD-1:0] fnVal [NUM_FN];
  logic [WORD-1:0] mixed;
  logic [XLEN-1:0] widened;

  // R1..R4: hash-256 sigma / sum networks
  assign fnVal[0] = rotR(word, 7)  ^ rotR(word, 18) ^ (word >> 3);
  assign fnVal[1] = rotR(word, 17) ^ rotR(word, 19) ^ (word >> 10);
  assign fnVal[2] = rotR(word, 2)  ^ rotR(word, 13) ^ rotR(word, 22);
  assign fnVal[3] = rotR(word, 6)  ^ rotR(word, 11) ^ rotR(word, 25);
  // R5, R6: permutation networks
  assign fnVal[4] = word ^ rotL(word, 9)  ^ rotL(word, 17);
  assign fnVal[5] = word ^ rotL(word, 15) ^ rotL(word, 23);

  // AND-OR select: all networks always evaluate, fixed depth
  always_comb begin
    mixed = '0;
    for (int i = 0; i < NUM_FN; i++) begin
      if (strobe.fnHot[i]) mixed = mixed | fnVal[i];
    end
  end

  if (EXT_W > 0) begin : g_wide
    assign widened = {{EXT_W{mixed[WORD-1]}}, mixed};

    a_r8_sign_ext: assert property (@(posedge clk) disable iff (!rstN)
      outValid |-> (resultOut[XLEN-1:WORD] == {EXT_W{resultOut[WORD-1]}}));
  end else begin : g_narrow
    assign widened = mixed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      resultOut <= '0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) resultOut <= widened;
    end
  end

  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> (!outValid && $stable(resultOut)));

  a_r7_single_fn: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.fnHot));

  a_r7_zero_unused: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.fnHot == '0) |=> (resultOut == '0));

endmodule

// File: rtl/hash_mix_unit.sv
module hash_mix_unit
  import hash_mix_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [2:0]      funcSel,
  input  logic [XLEN-1:0] srcIn,
  output logic            outValid,
  output logic [XLEN-1:0] resultOut
);

  hashStrobeT strobe;

  // R8: only the low word feeds the datapath
  if (XLEN > WORD) begin : g_hi
    logic unusedHigh;
    assign unusedHigh = ^srcIn[XLEN-1:WORD];
  end

  hash_mix_ctrl u_ctrl (
    .inValid (inValid),
    .funcSel (funcSel),
    .strobe  (strobe)
  );

  hash_mix_dp #(.XLEN(XLEN)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .word      (srcIn[WORD-1:0]),
    .outValid  (outValid),
    .resultOut (resultOut)
  );

endmodule

// File: tb/tb_hash_mix_unit.sv
`timescale 1ns/1ps
module tb_hash_mix_unit;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, inValid;
  logic [2:0]  funcSel;
  logic [63:0] srcIn;
  logic        outValid, outValid32;
  logic [63:0] resultOut;
  logic [31:0] result32;

  hash_mix_unit #(.XLEN(64)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .funcSel(funcSel),
    .srcIn(srcIn), .outValid(outValid), .resultOut(resultOut));

  hash_mix_unit #(.XLEN(32)) dut32 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .funcSel(funcSel),
    .srcIn(srcIn[31:0]), .outValid(outValid32), .resultOut(result32));

  typedef struct {
    logic [2:0]  sel;
    logic [31:0] val;
  } expT;

  expT         q[$];
  int          errors = 0;
  int          checks = 0;
  logic        started = 1'b0;
  logic        haveLast = 1'b0;
  logic [63:0] lastExp = '0;

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] t;
    t = {x, x} >> n;
    return t[31:0];
  endfunction

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return rr(x, 32 - n);
  endfunction

  function automatic logic [31:0] model(input logic [2:0] s, input logic [31:0] x);
    case (s)
      3'd0:    return rr(x, 7) ^ rr(x, 18) ^ (x >> 3);
      3'd1:    return rr(x, 17) ^ rr(x, 19) ^ (x >> 10);
      3'd2:    return rr(x, 2) ^ rr(x, 13) ^ rr(x, 22);
      3'd3:    return rr(x, 6) ^ rr(x, 11) ^ rr(x, 25);
      3'd4:    return x ^ rl(x, 9) ^ rl(x, 17);
      3'd5:    return x ^ rl(x, 15) ^ rl(x, 23);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] s);
    case (s)
      3'd0:    return "R1";
      3'd1:    return "R2";
      3'd2:    return "R3";
      3'd3:    return "R4";
      3'd4:    return "R5";
      3'd5:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] s, input logic [63:0] v);
    expT e;
    @(negedge clk);
    inValid = 1'b1;
    funcSel = s;
    srcIn   = v;
    e.sel = s;
    e.val = model(s, v[31:0]);
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
    funcSel = 3'd2;
    srcIn   = 64'hF0F0_1234_8765_ABCD;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (started) begin
      if (outValid) begin
        if (q.size() == 0) begin
          check(1'b0, "R9", "valid without request", {63'd0, outValid}, 64'd0);
        end else begin
          expT         e;
          logic [63:0] e64;
          e   = q.pop_front();
          e64 = {{32{e.val[31]}}, e.val};
          check(resultOut[31:0] == e.val, tagOf(e.sel), "low word 64b",
                {32'd0, resultOut[31:0]}, {32'd0, e.val});
          check(resultOut[63:32] == e64[63:32], "R8", "upper half",
                {32'd0, resultOut[63:32]}, {32'd0, e64[63:32]});
          check(outValid32 && result32 == e.val, tagOf(e.sel), "32b build",
                {31'd0, outValid32, result32}, {32'd1, e.val});
          lastExp  = e64;
          haveLast = 1'b1;
        end
      end else if (haveLast) begin
        check(resultOut == lastExp && !outValid32 && result32 == lastExp[31:0],
              "R11", "hold while idle", resultOut, lastExp);
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    rstN    = 1'b0;
    inValid = 1'b1;
    funcSel = 3'd4;
    srcIn   = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    check(!outValid && resultOut == 64'd0 && !outValid32 && result32 == 32'd0,
          "R10", "in reset", resultOut, 64'd0);
    inValid = 1'b0;
    rstN    = 1'b1;
    @(negedge clk);
    check(!outValid && resultOut == 64'd0, "R10", "after reset", resultOut, 64'd0);
    started = 1'b1;

    n = 0;
    for (int s = 0; s < 8; s++) begin
      logic [31:0] pats[5];
      pats[0] = 32'h0000_0000;
      pats[1] = 32'hFFFF_FFFF;
      pats[2] = 32'h8000_0001;
      pats[3] = 32'h1234_5678;
      pats[4] = 32'hA5A5_A5A5;
      for (int k = 0; k < 5; k++) begin
        // nonzero upper halves, both polarities of bit 63, to probe R8
        drive(3'(s), {((k % 2) == 1) ? 32'hDEAD_BEEF : 32'h5A00_0F0F, pats[k]});
        n++;
        if (n % 7 == 0) idle();
      end
      for (int b = 0; b < 32; b++) begin
        drive(3'(s), {32'hC3C3_0000 ^ 32'(b), 32'd1 << b});
        n++;
        if (n % 7 == 0) idle();
      end
    end
    idle();
    idle();
    idle();
    check(q.size() == 0, "R9", "all answered", 64'(q.size()), 64'd0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule